// File: doc/BRIEF.md
# Interrupt Delay and Moderation Unit

This unit sits between the receive and transmit descriptor engines of a network controller and the interrupt line to the host. It watches two event strobes, one for each received packet and one for each transmit descriptor completed. For each direction it runs two delay timers. The first is a packet delay that starts again on every new event. The second is an absolute delay that starts on the first event after idle and is never restarted. When either timer of a direction expires, the unit sends that direction's writeback engine a one-cycle flush request. This flush writes back every used descriptor with no alignment rounding. In the same cycle the unit records the direction's cause bit.

Recorded causes are kept in a pending set and gated by an enable mask. A throttle timer limits how often the line can rise, so the host does not see an interrupt storm. Two kinds of post skip the throttle: a post made at once because the packet delay is programmed to zero, and a write that sets mask bits. All intervals count in units of 1024 ns. A prescaler of `UNIT_CYCLES` clock cycles produces each unit. Software reads the pending causes and clears them with a single read strobe.

Top module: `intr_moderator`

## Requirements
- R1: After reset the interrupt line is low, both flush requests are low, the pending causes read as zero and the mask is zero.
- R2: Cause encoding is bit 0 for transmit descriptors written and bit 1 for receive timer. A receive event with a nonzero packet delay D starts a timer that restarts on each later receive event. If no further event arrives, the timer expires D units after the last event, pulses `rxFlushReq` for one cycle and sets pending bit 1.
- R3: The receive absolute delay A (nonzero) starts on the first receive event after idle and is not restarted by later events. It forces the flush and pending bit 1 A units after that first event, even while events keep arriving.
- R4: The transmit packet delay and transmit absolute delay timers behave like their receive counterparts. On expiry they pulse `txFlushReq` and set pending bit 0, and they never touch the receive side.
- R5: An event whose packet delay is programmed to zero flushes and posts its cause in the next cycle. Such a post is immediate and raises the line even while the throttle is running.
- R6: A post always sets its pending bit. The line is high only while some pending bit is also set in the mask.
- R7: A mask set write (`maskSetWr`, set wins over clear) re-evaluates the pending bits and raises the line in the next cycle, even while the throttle is running. A mask clear write drops the line in the next cycle once no enabled pending bit remains.
- R8: Each rising edge of the line loads the throttle with `throttleIntv` units. A non-immediate post cannot raise the line again until the throttle has counted down to zero. A throttle value of zero disables throttling.
- R9: `causeRdData` always shows the pending bits. A `causeRdStb` clears them and drops the line in the next cycle. A post arriving in the same cycle as the read survives the clear.
- R10: One timer unit is `UNIT_CYCLES` clock cycles (1024 ns of the clock). A delay of D units expires between D-1 and D units after it is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxPktEvt | input | 1 | One-cycle strobe per received packet |
| txDoneEvt | input | 1 | One-cycle strobe per transmit descriptor done |
| rxPktDly | input | TW | Receive packet delay in units, zero posts at once |
| rxAbsDly | input | TW | Receive absolute delay in units, zero disables it |
| txPktDly | input | TW | Transmit packet delay in units, zero posts at once |
| txAbsDly | input | TW | Transmit absolute delay in units, zero disables it |
| throttleIntv | input | TW | Minimum spacing between line assertions in units |
| maskSetWr | input | 1 | Set mask bits given by maskWrData |
| maskClrWr | input | 1 | Clear mask bits given by maskWrData |
| maskWrData | input | 2 | Mask bits to set or clear (bit 0 tx, bit 1 rx) |
| causeRdStb | input | 1 | Read-and-clear of the pending causes |
| causeRdData | output | 2 | Pending causes (bit 0 tx, bit 1 rx) |
| rxFlushReq | output | 1 | One-cycle receive writeback request, no alignment |
| txFlushReq | output | 1 | One-cycle transmit writeback request, no alignment |
| irqOut | output | 1 | Interrupt line to the host |

## Verification
The bench spaces receive events closer together than the packet delay, so the packet timer keeps restarting. A design that failed to restart it would flush early, and one that restarted the absolute timer on each event would never flush in that run. It also posts a cause while the throttle is counting. A design that ignored the throttle would raise the line too soon, and one that throttled zero-delay posts or mask set writes would hold the line low where it must rise. A read strobe is made to collide with an immediate post. A design that cleared after setting would lose that cause. Masked posts are checked: a design that gated the pending bit instead of only the line would read back zero.

// File: rtl/intr_mod_pkg.sv
package intr_mod_pkg;
  localparam int CAUSE_TX = 0;
  localparam int CAUSE_RX = 1;
  localparam int NUM_DIR  = 2;

  typedef struct packed {
    logic throttleLoad;
  } ctlStrobe_t;

  typedef struct packed {
    logic [NUM_DIR-1:0] timerFire;
    logic [NUM_DIR-1:0] nowFire;
    logic               throttleBusy;
  } dpStatus_t;
endpackage

// File: rtl/intr_delay_pair.sv
module intr_delay_pair #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          unitTick,
  input  logic          evt,
  input  logic [TW-1:0] pktDly,
  input  logic [TW-1:0] absDly,
  output logic          timerFire,
  output logic          nowFire
);
  logic [TW-1:0] pktCnt, absCnt;
  logic          pktRun, absRun;
  logic          pktDone, absDone, flushAny;

  assign pktDone   = unitTick && pktRun && (pktCnt == TW'(1));
  assign absDone   = unitTick && absRun && (absCnt == TW'(1));
  assign timerFire = pktDone || absDone;
  assign nowFire   = evt && (pktDly == '0);
  assign flushAny  = timerFire || nowFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktCnt <= '0;
      absCnt <= '0;
      pktRun <= 1'b0;
      absRun <= 1'b0;
    end else begin
      if (flushAny) begin
        pktRun <= 1'b0;
        absRun <= 1'b0;
      end else if (unitTick) begin
        if (pktRun) pktCnt <= pktCnt - TW'(1);
        if (absRun) absCnt <= absCnt - TW'(1);
      end
      if (evt && (pktDly != '0)) begin
        pktCnt <= pktDly;
        pktRun <= 1'b1;
        if ((!absRun || timerFire) && (absDly != '0)) begin
          absCnt <= absDly;
          absRun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/intr_mod_datapath.sv
module intr_mod_datapath
  import intr_mod_pkg::*;
#(
  parameter int TW          = 16,
  parameter int UNIT_CYCLES = 102
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxPktEvt,
  input  logic          txDoneEvt,
  input  logic [TW-1:0] rxPktDly,
  input  logic [TW-1:0] rxAbsDly,
  input  logic [TW-1:0] txPktDly,
  input  logic [TW-1:0] txAbsDly,
  input  logic [TW-1:0] throttleIntv,
  input  ctlStrobe_t    ctl,
  output dpStatus_t     dpSt,
  output logic [TW-1:0] thrCnt,
  output logic          rxFlushReq,
  output logic          txFlushReq
);
  localparam int PW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;

  logic [PW-1:0]      preCnt;
  logic               unitTick;
  logic [NUM_DIR-1:0] evtVec, tFire, nFire;
  logic [TW-1:0]      pktArr [NUM_DIR];
  logic [TW-1:0]      absArr [NUM_DIR];
  logic [NUM_DIR-1:0] flushQ;

  generate
    if (UNIT_CYCLES > 1) begin : g_pre
      assign unitTick = (preCnt == PW'(UNIT_CYCLES - 1));
      always_ff @(posedge clk) begin
        if (!rstN || unitTick) preCnt <= '0;
        else                   preCnt <= preCnt + PW'(1);
      end
    end else begin : g_nopre
      assign unitTick = 1'b1;
      always_ff @(posedge clk) preCnt <= '0;
    end
  endgenerate

  assign evtVec[CAUSE_TX] = txDoneEvt;
  assign evtVec[CAUSE_RX] = rxPktEvt;
  assign pktArr[CAUSE_TX] = txPktDly;
  assign pktArr[CAUSE_RX] = rxPktDly;
  assign absArr[CAUSE_TX] = txAbsDly;
  assign absArr[CAUSE_RX] = rxAbsDly;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    intr_delay_pair #(.TW(TW)) u_pair (
      .clk      (clk),
      .rstN     (rstN),
      .unitTick (unitTick),
      .evt      (evtVec[d]),
      .pktDly   (pktArr[d]),
      .absDly   (absArr[d]),
      .timerFire(tFire[d]),
      .nowFire  (nFire[d])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrCnt <= '0;
      flushQ <= '0;
    end else begin
      flushQ <= tFire | nFire;
      if (ctl.throttleLoad)                 thrCnt <= throttleIntv;
      else if (unitTick && thrCnt != '0)    thrCnt <= thrCnt - TW'(1);
    end
  end

  assign dpSt.timerFire    = tFire;
  assign dpSt.nowFire      = nFire;
  assign dpSt.throttleBusy = (thrCnt != '0);
  assign rxFlushReq        = flushQ[CAUSE_RX];
  assign txFlushReq        = flushQ[CAUSE_TX];
endmodule

// File: rtl/intr_mod_ctrl.sv
module intr_mod_ctrl
  import intr_mod_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStatus_t          dpSt,
  input  logic               maskSetWr,
  input  logic               maskClrWr,
  input  logic [NUM_DIR-1:0] maskWrData,
  input  logic               causeRdStb,
  output ctlStrobe_t         ctl,
  output logic [NUM_DIR-1:0] pendBits,
  output logic [NUM_DIR-1:0] maskBits,
  output logic               irqOut
);
  logic [NUM_DIR-1:0] posts, pendNext, maskNext;
  logic               want, grant, irqNext;

  assign posts = dpSt.timerFire | dpSt.nowFire;

  always_comb begin
    pendNext = (causeRdStb ? '0 : pendBits) | posts;
    maskNext = maskBits;
    if (maskSetWr)      maskNext = maskBits | maskWrData;
    else if (maskClrWr) maskNext = maskBits & ~maskWrData;
    want    = |(pendNext & maskNext);
    grant   = !dpSt.throttleBusy || (|dpSt.nowFire) || maskSetWr;
    irqNext = want && (irqOut || grant);
  end

  assign ctl.throttleLoad = irqNext && !irqOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendBits <= '0;
      maskBits <= '0;
      irqOut   <= 1'b0;
    end else begin
      pendBits <= pendNext;
      maskBits <= maskNext;
      irqOut   <= irqNext;
    end
  end
endmodule

// File: rtl/intr_moderator.sv
module intr_moderator
  import intr_mod_pkg::*;
#(
  parameter int TW          = 16,
  parameter int UNIT_CYCLES = 102
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxPktEvt,
  input  logic          txDoneEvt,
  input  logic [TW-1:0] rxPktDly,
  input  logic [TW-1:0] rxAbsDly,
  input  logic [TW-1:0] txPktDly,
  input  logic [TW-1:0] txAbsDly,
  input  logic [TW-1:0] throttleIntv,
  input  logic          maskSetWr,
  input  logic          maskClrWr,
  input  logic [1:0]    maskWrData,
  input  logic          causeRdStb,
  output logic [1:0]    causeRdData,
  output logic          rxFlushReq,
  output logic          txFlushReq,
  output logic          irqOut
);
  ctlStrobe_t         ctl;
  dpStatus_t          dpSt;
  logic [TW-1:0]      thrCnt;
  logic [NUM_DIR-1:0] pendBits, maskBits;

  intr_mod_datapath #(.TW(TW), .UNIT_CYCLES(UNIT_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .rxPktEvt(rxPktEvt), .txDoneEvt(txDoneEvt),
    .rxPktDly(rxPktDly), .rxAbsDly(rxAbsDly), .txPktDly(txPktDly),
    .txAbsDly(txAbsDly), .throttleIntv(throttleIntv), .ctl(ctl),
    .dpSt(dpSt), .thrCnt(thrCnt), .rxFlushReq(rxFlushReq),
    .txFlushReq(txFlushReq)
  );

  intr_mod_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dpSt(dpSt), .maskSetWr(maskSetWr),
    .maskClrWr(maskClrWr), .maskWrData(maskWrData), .causeRdStb(causeRdStb),
    .ctl(ctl), .pendBits(pendBits), .maskBits(maskBits), .irqOut(irqOut)
  );

  assign causeRdData = pendBits;
endmodule

// File: rtl/intr_moderator_chk.sv
module intr_moderator_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          irqOut,
  input logic          rxFlushReq,
  input logic          txFlushReq,
  input logic          causeRdStb,
  input logic          maskSetWr,
  input logic          rxPktEvt,
  input logic          txDoneEvt,
  input logic [TW-1:0] rxPktDly,
  input logic [TW-1:0] txPktDly,
  input logic [1:0]    pendBits,
  input logic [1:0]    maskBits,
  input logic [TW-1:0] thrCnt
);
  AST_RX_FLUSH_POSTS: assert property (@(posedge clk) disable iff (!rstN)
    rxFlushReq |-> pendBits[1]);                                   // R2
  AST_TX_FLUSH_POSTS: assert property (@(posedge clk) disable iff (!rstN)
    txFlushReq |-> pendBits[0]);                                   // R4
  AST_LINE_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|(pendBits & maskBits)));                          // R6
  AST_THROTTLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqOut) && !$past(maskSetWr)
      && !$past(rxPktEvt && rxPktDly == '0)
      && !$past(txDoneEvt && txPktDly == '0)) |-> ($past(thrCnt) == '0)); // R8
  AST_READ_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (causeRdStb && !maskSetWr) |=> (!irqOut || rxFlushReq || txFlushReq)); // R9
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxFlushReq |=> !rxFlushReq || $past(rxPktEvt));                 // R5
endmodule

bind intr_moderator intr_moderator_chk #(.TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .rxFlushReq(rxFlushReq),
  .txFlushReq(txFlushReq), .causeRdStb(causeRdStb), .maskSetWr(maskSetWr),
  .rxPktEvt(rxPktEvt), .txDoneEvt(txDoneEvt), .rxPktDly(rxPktDly),
  .txPktDly(txPktDly), .pendBits(pendBits), .maskBits(maskBits),
  .thrCnt(thrCnt)
);

// File: tb/intr_moderator_bench.sv
module intr_moderator_bench;
  localparam int TW = 16;
  localparam int U  = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxPktEvt = 1'b0, txDoneEvt = 1'b0;
  logic [TW-1:0] rxPktDly = '0, rxAbsDly = '0, txPktDly = '0, txAbsDly = '0;
  logic [TW-1:0] throttleIntv = '0;
  logic          maskSetWr = 1'b0, maskClrWr = 1'b0, causeRdStb = 1'b0;
  logic [1:0]    maskWrData = '0;
  logic [1:0]    causeRdData;
  logic          rxFlushReq, txFlushReq, irqOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  intr_moderator #(.TW(TW), .UNIT_CYCLES(U)) u_intr_moderator (
    .clk(clk), .rstN(rstN), .rxPktEvt(rxPktEvt), .txDoneEvt(txDoneEvt),
    .rxPktDly(rxPktDly), .rxAbsDly(rxAbsDly), .txPktDly(txPktDly),
    .txAbsDly(txAbsDly), .throttleIntv(throttleIntv), .maskSetWr(maskSetWr),
    .maskClrWr(maskClrWr), .maskWrData(maskWrData), .causeRdStb(causeRdStb),
    .causeRdData(causeRdData), .rxFlushReq(rxFlushReq),
    .txFlushReq(txFlushReq), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseRx();
    @(negedge clk) rxPktEvt = 1'b1;
    @(negedge clk) rxPktEvt = 1'b0;
  endtask

  task automatic pulseTx();
    @(negedge clk) txDoneEvt = 1'b1;
    @(negedge clk) txDoneEvt = 1'b0;
  endtask

  task automatic readClear();
    @(negedge clk) causeRdStb = 1'b1;
    @(negedge clk) causeRdStb = 1'b0;
  endtask

  task automatic maskWrite(input bit setNotClr, input logic [1:0] bits);
    @(negedge clk);
    maskWrData = bits;
    if (setNotClr) maskSetWr = 1'b1; else maskClrWr = 1'b1;
    @(negedge clk);
    maskSetWr = 1'b0;
    maskClrWr = 1'b0;
  endtask

  task automatic waitFlush(input bit rxSide, input int maxCyc, output int n);
    n = 0;
    while (!(rxSide ? rxFlushReq : txFlushReq) && n < maxCyc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic testReset();
    check(irqOut == 1'b0, "R1 irq", int'(irqOut), 0);
    check(causeRdData == 2'b00, "R1 pending", int'(causeRdData), 0);
    check(!rxFlushReq && !txFlushReq, "R1 flush", int'({rxFlushReq, txFlushReq}), 0);
  endtask

  task automatic testRxRestart();
    int n;
    bit early;
    rxPktDly = 16'd3; rxAbsDly = '0; throttleIntv = '0;
    maskWrite(1'b1, 2'b11);
    early = 1'b0;
    for (int k = 0; k < 4; k++) begin
      pulseRx();
      for (int j = 0; j < 2 * U - 2; j++) begin
        @(negedge clk);
        if (rxFlushReq) early = 1'b1;
      end
    end
    check(!early, "R2 restart holds flush", int'(early), 0);
    pulseRx();
    waitFlush(1'b1, 4 * U, n);
    check(n >= 2 * U && n <= 3 * U + 1, "R2/R10 packet delay window", n, 3 * U);
    @(negedge clk);
    check(rxFlushReq == 1'b0, "R2 flush one cycle", int'(rxFlushReq), 0);
    check(causeRdData == 2'b10, "R2 rx cause bit1", int'(causeRdData), 2);
    check(irqOut == 1'b1, "R6 irq enabled", int'(irqOut), 1);
    @(negedge clk) causeRdStb = 1'b1;
    check(causeRdData == 2'b10, "R9 read data", int'(causeRdData), 2);
    @(negedge clk) causeRdStb = 1'b0;
    check(causeRdData == 2'b00 && irqOut == 1'b0, "R9 read clears",
          int'({causeRdData, irqOut}), 0);
  endtask

  task automatic testRxAbsolute();
    int n;
    bit seen;
    rxPktDly = 16'd3; rxAbsDly = 16'd5;
    n = 0; seen = 1'b0;
    for (int k = 0; k < 8 && !seen; k++) begin
      pulseRx();
      if (k != 0) n += 2;
      for (int j = 0; j < 2 * U - 2 && !seen; j++) begin
        if (rxFlushReq) seen = 1'b1;
        else begin
          @(negedge clk);
          n++;
        end
      end
    end
    check(seen, "R3 absolute fires", int'(seen), 1);
    check(n >= 4 * U && n <= 5 * U + 1, "R3/R10 absolute window", n, 5 * U);
    check(txFlushReq == 1'b0, "R4 rx leaves tx alone", int'(txFlushReq), 0);
    repeat (6 * U) @(negedge clk);
    readClear();
    rxAbsDly = '0;
  endtask

  task automatic testTx();
    int n;
    bit rxSeen;
    txPktDly = 16'd2; txAbsDly = '0;
    pulseTx();
    rxSeen = 1'b0;
    waitFlush(1'b0, 3 * U, n);
    check(n >= U && n <= 2 * U + 1, "R4 tx packet window", n, 2 * U);
    check(causeRdData == 2'b01, "R4 tx cause bit0", int'(causeRdData), 1);
    readClear();
    txPktDly = 16'd4; txAbsDly = 16'd2;
    pulseTx();
    n = 0;
    while (!txFlushReq && n < 5 * U) begin
      @(negedge clk);
      n++;
      if (rxFlushReq) rxSeen = 1'b1;
    end
    check(n >= U && n <= 2 * U + 1, "R4 tx absolute window", n, 2 * U);
    check(!rxSeen, "R4 no rx flush", int'(rxSeen), 0);
    readClear();
  endtask

  task automatic testThrottle();
    int t0, t1, n;
    throttleIntv = 16'd6; rxPktDly = 16'd1; txPktDly = '0; txAbsDly = '0;
    pulseRx();
    n = 0;
    while (!irqOut && n < 3 * U) begin @(negedge clk); n++; end
    t0 = cyc;
    check(irqOut == 1'b1, "R8 first rise", int'(irqOut), 1);
    readClear();
    pulseRx();
    waitFlush(1'b1, 3 * U, n);
    check(irqOut == 1'b0, "R8 held by throttle", int'(irqOut), 0);
    n = 0;
    while (!irqOut && n < 8 * U) begin @(negedge clk); n++; end
    t1 = cyc;
    check((t1 - t0) >= 5 * U && (t1 - t0) <= 6 * U + 2, "R8 throttle spacing",
          t1 - t0, 6 * U);
    readClear();
    pulseTx();
    check(irqOut == 1'b1 && causeRdData == 2'b01, "R5 zero delay bypasses throttle",
          int'({irqOut, causeRdData}), 5);
    readClear();
    maskWrite(1'b0, 2'b01);
    pulseTx();
    check(causeRdData == 2'b01 && irqOut == 1'b0, "R6 masked post pends",
          int'({irqOut, causeRdData}), 1);
    maskWrite(1'b1, 2'b01);
    check(irqOut == 1'b1, "R7 mask set raises under throttle", int'(irqOut), 1);
    readClear();
    throttleIntv = '0;
    repeat (7 * U) @(negedge clk);
  endtask

  task automatic testMaskAndCollision();
    rxPktDly = '0; txPktDly = '0;
    maskWrite(1'b0, 2'b10);
    pulseRx();
    check(causeRdData == 2'b10 && irqOut == 1'b0, "R6 rx masked",
          int'({irqOut, causeRdData}), 2);
    maskWrite(1'b1, 2'b10);
    check(irqOut == 1'b1, "R7 mask set re-evaluates", int'(irqOut), 1);
    maskWrite(1'b0, 2'b10);
    check(irqOut == 1'b0 && causeRdData == 2'b10, "R7 mask clear drops line",
          int'({irqOut, causeRdData}), 2);
    @(negedge clk);
    txDoneEvt = 1'b1;
    causeRdStb = 1'b1;
    check(causeRdData == 2'b10, "R9 read shows old", int'(causeRdData), 2);
    @(negedge clk);
    txDoneEvt = 1'b0;
    causeRdStb = 1'b0;
    check(causeRdData == 2'b01, "R9 colliding post kept", int'(causeRdData), 1);
    check(irqOut == 1'b1, "R9 line from kept tx cause", int'(irqOut), 1);
    readClear();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRxRestart();
    testRxAbsolute();
    testTx();
    testThrottle();
    testMaskAndCollision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule